// File: doc/BRIEF.md
# Flagged Teletype I/O Controller

This block serves the input/output transfer instructions of a 12-bit processor for two character devices: a keyboard/reader and a printer/punch. Each device owns a character buffer and a ready flag. When the processor presents an I/O instruction, the block returns a same-cycle answer. The answer holds a replacement accumulator value, a write enable for the accumulator and a skip request. The flags and buffers change on the following clock edge.

The low three bits of the instruction are independent micro-operations, and any combination may be set. The value-1 bit tests the device flag and asks for a skip. The value-2 bit clears the flag, and on the keyboard it also clears the accumulator. The value-4 bit transfers a character. The keyboard side loads its buffer from a strobed byte. The printer side launches a character with a one-cycle start pulse. It raises its flag when the printer answers with a done pulse, or at once when the character is zero and is therefore not sent.

Top module: `tty_io_ctrl`

## Requirements
- R1: An instruction acts only when `io_valid` is high, bits 11..9 equal 110 and bits 8..3 equal octal 03 (keyboard) or octal 04 (printer). Any other instruction gives `ac_we`=0 and `skip_req`=0, and `ac_out` equals `ac_in`.
- R2: A high `kbd_strobe` loads `kbd_char` into the keyboard buffer and sets the keyboard flag on that clock edge.
- R3: Keyboard op bit 0 (value 1) raises `skip_req` in the same cycle if and only if the keyboard flag is set. Skip alone does not write the accumulator.
- R4: Keyboard op bit 1 (value 2) gives `ac_we`=1 with `ac_out`=0 and clears the keyboard flag.
- R5: Keyboard op bit 2 (value 4) gives `ac_we`=1 with `ac_out` = `ac_in` OR the buffer zero-extended into bits 7..0. Without bit 1, the flag is left unchanged.
- R6: Keyboard ops 6 (bits 1 and 2) give `ac_out` equal to the zero-extended buffer and clear the flag.
- R7: A strobe in the same cycle as a keyboard clear leaves the flag set and loads the new character. A transfer in that cycle returns the previous buffer contents.
- R8: Printer op bit 0 raises `skip_req` if and only if the printer flag is set. Printer op bit 1 clears the printer flag.
- R9: Printer op bit 2 with a nonzero `ac_in[7:0]` produces, on the next cycle, a one-cycle `prn_start` with `prn_char` = `ac_in[7:0]`. The printer flag is set on the clock edge that samples `prn_done`.
- R10: Printer op bit 2 with `ac_in[7:0]` = 0 produces no `prn_start` and sets the printer flag on the next clock edge.
- R11: Printer ops 6 (bits 1 and 2) with a nonzero character clear the flag, which stays clear until `prn_done`.
- R12: Printer instructions never write the accumulator (`ac_we`=0).
- R13: After reset both flags are clear and `prn_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Instruction word is valid this cycle |
| io_instr | input | 12 | Instruction word |
| ac_in | input | 12 | Current accumulator |
| ac_out | output | 12 | Replacement accumulator value |
| ac_we | output | 1 | Accumulator write enable |
| skip_req | output | 1 | Skip the next instruction |
| kbd_strobe | input | 1 | Keyboard character valid |
| kbd_char | input | 8 | Keyboard character |
| prn_char | output | 8 | Character sent to the printer |
| prn_start | output | 1 | One-cycle print start |
| prn_done | input | 1 | Printer finished the current character |

## Verification
A keyboard strobe can land in the same cycle as a keyboard instruction that clears the flag and reads the buffer. The flag update and the buffer load then compete with the clear and the read. The bench drives the strobe and the combined clear-and-read instruction on the same clock. It expects the accumulator to receive the previous character. It then confirms, through a flag-test instruction and a further transfer, that the flag remained set and that the new character was stored. A second overlap is a zero-valued print combined with a flag clear. There, the flag must end up set and no start pulse may appear.

// File: rtl/tty_io_pkg.sv
package tty_io_pkg;
   // One device's decoded micro-operations (instruction bits 0, 1, 2)
   typedef struct packed {
      logic xfer;   // value 4: transfer
      logic clr;    // value 2: clear flag
      logic tst;    // value 1: skip on flag
   } dev_ops_t;

   localparam logic [2:0] IO_OPCODE = 3'b110;
endpackage

// File: rtl/tty_io_decode.sv
module tty_io_decode
   import tty_io_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int DEV_W = 6,
   parameter logic [DEV_W-1:0] KBD_DEV = 6'o03,
   parameter logic [DEV_W-1:0] PRN_DEV = 6'o04
) (
   input  logic              valid_i,
   input  logic [WORD_W-1:0] instr_i,
   output dev_ops_t          kbd_ops_o,
   output dev_ops_t          prn_ops_o
);
   localparam int OPS_W = 3;
   localparam int DEV_LO = OPS_W;
   localparam int DEV_HI = OPS_W + DEV_W - 1;
   localparam int OPC_LO = DEV_HI + 1;

   if (WORD_W != OPC_LO + 3) begin : g_bad_width
      $error("tty_io_decode: WORD_W must equal DEV_W + 6");
   end
   if (KBD_DEV == PRN_DEV) begin : g_bad_dev
      $error("tty_io_decode: device codes must differ");
   end

   logic             io_sel;
   logic [DEV_W-1:0] dev;
   dev_ops_t         ops;

   always_comb begin
      io_sel    = valid_i && (instr_i[WORD_W-1:OPC_LO] == IO_OPCODE);
      dev       = instr_i[DEV_HI:DEV_LO];
      ops       = dev_ops_t'(instr_i[OPS_W-1:0]);
      kbd_ops_o = (io_sel && dev == KBD_DEV) ? ops : '0;
      prn_ops_o = (io_sel && dev == PRN_DEV) ? ops : '0;
   end
endmodule

// File: rtl/tty_kbd_unit.sv
module tty_kbd_unit
   import tty_io_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int CHAR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  dev_ops_t          ops_i,
   input  logic [WORD_W-1:0] ac_i,
   input  logic              strobe_i,
   input  logic [CHAR_W-1:0] char_i,
   output logic [WORD_W-1:0] ac_o,
   output logic              ac_we_o,
   output logic              skip_o
);
   if (CHAR_W > WORD_W) begin : g_bad_char
      $error("tty_kbd_unit: CHAR_W exceeds WORD_W");
   end

   logic              flag_q;
   logic [CHAR_W-1:0] buf_q;
   logic [WORD_W-1:0] char_ext;

   if (WORD_W > CHAR_W) begin : g_ext
      assign char_ext = {{(WORD_W - CHAR_W){1'b0}}, buf_q};
   end else begin : g_same
      assign char_ext = buf_q;
   end

   always_comb begin
      skip_o  = ops_i.tst && flag_q;
      ac_we_o = ops_i.clr || ops_i.xfer;
      ac_o    = (ops_i.clr ? '0 : ac_i) | (ops_i.xfer ? char_ext : '0);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
         buf_q  <= '0;
      end else begin
         if (strobe_i) begin
            flag_q <= 1'b1;        // new character outranks a clear
            buf_q  <= char_i;
         end else if (ops_i.clr) begin
            flag_q <= 1'b0;
         end
      end
   end

   p_strobe_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i |=> (flag_q && buf_q == $past(char_i)));
   p_clear_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ops_i.clr && !strobe_i) |=> !flag_q);
   p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ops_i.clr && !strobe_i) |=> (flag_q == $past(flag_q)));
   p_race_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ops_i.clr && strobe_i) |=> flag_q);
endmodule

// File: rtl/tty_prn_unit.sv
module tty_prn_unit
   import tty_io_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int CHAR_W = 8,
   parameter bit SUPPRESS_ZERO = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  dev_ops_t          ops_i,
   input  logic [WORD_W-1:0] ac_i,
   input  logic              done_i,
   output logic              skip_o,
   output logic [CHAR_W-1:0] char_o,
   output logic              start_o
);
   if (CHAR_W > WORD_W) begin : g_bad_char
      $error("tty_prn_unit: CHAR_W exceeds WORD_W");
   end

   logic              flag_q, busy_q;
   logic              emit, finish;
   logic [CHAR_W-1:0] out_char;

   assign out_char = ac_i[CHAR_W-1:0];

   if (SUPPRESS_ZERO) begin : g_sup
      assign emit = |out_char;
   end else begin : g_all
      assign emit = 1'b1;
   end

   always_comb begin
      skip_o = ops_i.tst && flag_q;
      finish = busy_q && done_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q  <= 1'b0;
         busy_q  <= 1'b0;
         start_o <= 1'b0;
         char_o  <= '0;
      end else begin
         flag_q  <= (flag_q && !ops_i.clr) || finish || (ops_i.xfer && !emit);
         start_o <= ops_i.xfer && emit;
         if (ops_i.xfer && emit) begin
            busy_q <= 1'b1;
            char_o <= out_char;
         end else if (finish) begin
            busy_q <= 1'b0;
         end
      end
   end

   p_start_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ops_i.xfer && emit) |=> (start_o && char_o == $past(out_char)));
   p_done_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      finish |=> flag_q);
   p_busy_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ops_i.xfer && ops_i.clr && emit) |=> !flag_q);
   p_clr_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ops_i.clr && !ops_i.xfer && !finish) |=> !flag_q);

   if (SUPPRESS_ZERO) begin : g_zero_chk
      p_zero_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ops_i.xfer && out_char == '0) |=> (flag_q && !start_o));
   end
endmodule

// File: rtl/tty_io_ctrl.sv
module tty_io_ctrl
   import tty_io_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int CHAR_W = 8,
   parameter int DEV_W = 6,
   parameter logic [DEV_W-1:0] KBD_DEV = 6'o03,
   parameter logic [DEV_W-1:0] PRN_DEV = 6'o04,
   parameter bit SUPPRESS_ZERO = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              io_valid,
   input  logic [WORD_W-1:0] io_instr,
   input  logic [WORD_W-1:0] ac_in,
   output logic [WORD_W-1:0] ac_out,
   output logic              ac_we,
   output logic              skip_req,
   input  logic              kbd_strobe,
   input  logic [CHAR_W-1:0] kbd_char,
   output logic [CHAR_W-1:0] prn_char,
   output logic              prn_start,
   input  logic              prn_done
);
   dev_ops_t          kbd_ops, prn_ops;
   logic [WORD_W-1:0] kbd_ac;
   logic              kbd_we, kbd_skip, prn_skip;

   tty_io_decode #(
      .WORD_W(WORD_W), .DEV_W(DEV_W), .KBD_DEV(KBD_DEV), .PRN_DEV(PRN_DEV)
   ) u_dec (
      .valid_i(io_valid), .instr_i(io_instr),
      .kbd_ops_o(kbd_ops), .prn_ops_o(prn_ops)
   );

   tty_kbd_unit #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_kbd (
      .clk_i(clk_i), .rst_ni(rst_ni), .ops_i(kbd_ops), .ac_i(ac_in),
      .strobe_i(kbd_strobe), .char_i(kbd_char),
      .ac_o(kbd_ac), .ac_we_o(kbd_we), .skip_o(kbd_skip)
   );

   tty_prn_unit #(
      .WORD_W(WORD_W), .CHAR_W(CHAR_W), .SUPPRESS_ZERO(SUPPRESS_ZERO)
   ) u_prn (
      .clk_i(clk_i), .rst_ni(rst_ni), .ops_i(prn_ops), .ac_i(ac_in),
      .done_i(prn_done), .skip_o(prn_skip), .char_o(prn_char),
      .start_o(prn_start)
   );

   always_comb begin
      ac_we    = kbd_we;
      ac_out   = kbd_we ? kbd_ac : ac_in;
      skip_req = kbd_skip || prn_skip;
   end

   p_only_one_dev_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({kbd_ops != '0, prn_ops != '0}) <= 1);
   p_no_write_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !io_valid |-> (!ac_we && !skip_req));
   p_prn_no_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prn_ops != '0) |-> !ac_we);
endmodule

// File: tb/tty_io_ctrl_tb_top.sv
`timescale 1ns/1ps
module tty_io_ctrl_tb_top;
   localparam int PRN_LAT = 5;

   typedef struct {
      logic        we;
      logic [11:0] ac;
      logic        skip;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_valid = 1'b0;
   logic [11:0] io_instr = '0;
   logic [11:0] ac_in = '0;
   logic [11:0] ac_out;
   logic        ac_we, skip_req;
   logic        kbd_strobe = 1'b0;
   logic [7:0]  kbd_char = '0;
   logic [7:0]  prn_char;
   logic        prn_start;
   logic        prn_done = 1'b0;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 1'b0;
   exp_t cpu_q[$];
   logic [7:0] prn_q[$];

   always #2 clk = ~clk;   // 250 MHz

   tty_io_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .io_valid(io_valid), .io_instr(io_instr),
      .ac_in(ac_in), .ac_out(ac_out), .ac_we(ac_we), .skip_req(skip_req),
      .kbd_strobe(kbd_strobe), .kbd_char(kbd_char), .prn_char(prn_char),
      .prn_start(prn_start), .prn_done(prn_done)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: called at a falling edge, returns at the next one
   task automatic issue(logic [11:0] instr, logic [11:0] ac,
                        logic we, logic [11:0] eac, logic sk, string req);
      exp_t e;
      e.we = we; e.ac = eac; e.skip = sk; e.req = req;
      cpu_q.push_back(e);
      io_valid = 1'b1; io_instr = instr; ac_in = ac;
      @(negedge clk);
      io_valid = 1'b0; io_instr = '0;
   endtask

   task automatic strobe(logic [7:0] c);
      kbd_strobe = 1'b1; kbd_char = c;
      @(negedge clk);
      kbd_strobe = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops an expectation for every presented instruction
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (io_valid) begin
            if (cpu_q.size() == 0) begin
               check("R1 unexpected instruction", 0, 1);
            end else begin
               exp_t e;
               e = cpu_q.pop_front();
               check(e.req, {18'd0, ac_we, ac_out, skip_req},
                     {18'd0, e.we, e.ac, e.skip});
            end
         end
      end
   end

   // printer model: checks each started character, answers after PRN_LAT
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && prn_start) begin
            if (prn_q.size() == 0) begin
               check("R10 unexpected prn_start", {24'd0, prn_char}, 32'hFFFF_FFFF);
            end else begin
               logic [7:0] c;
               c = prn_q.pop_front();
               check("R9 prn_char", {24'd0, prn_char}, {24'd0, c});
            end
            repeat (PRN_LAT) @(negedge clk);
            prn_done = 1'b1;
            @(negedge clk);
            prn_done = 1'b0;
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      idle(2);
      #1;
      check("R13 prn_start in reset", {31'd0, prn_start}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      // reset state, observed through the flag tests
      issue(12'o6031, 12'o1234, 0, 12'o1234, 0, "R13 kbd flag clear");
      issue(12'o6041, 12'o0000, 0, 12'o0000, 0, "R13 prn flag clear");
      // keyboard
      strobe(8'h41);
      issue(12'o6031, 12'o0007, 0, 12'o0007, 1, "R3 skip on kbd flag");
      issue(12'o6031, 12'o0000, 0, 12'o0000, 1, "R2 flag held");
      issue(12'o6034, 12'hF00, 1, 12'hF41, 0, "R5 or transfer");
      issue(12'o6031, 12'o0000, 0, 12'o0000, 1, "R5 flag kept");
      issue(12'o6032, 12'h123, 1, 12'h000, 0, "R4 clear ac");
      issue(12'o6031, 12'o0000, 0, 12'o0000, 0, "R4 flag cleared");
      strobe(8'h5A);
      issue(12'o6036, 12'hFFF, 1, 12'h05A, 0, "R6 clear and read");
      issue(12'o6031, 12'o0000, 0, 12'o0000, 0, "R6 flag cleared");
      // same-cycle strobe and clear
      strobe(8'h33);
      kbd_strobe = 1'b1; kbd_char = 8'h44;
      issue(12'o6036, 12'h000, 1, 12'h033, 0, "R7 old buffer read");
      kbd_strobe = 1'b0;
      issue(12'o6031, 12'o0000, 0, 12'o0000, 1, "R7 flag survives");
      issue(12'o6034, 12'h000, 1, 12'h044, 0, "R7 new char stored");
      // decode filtering, keyboard flag is set here
      issue(12'o6051, 12'h2AA, 0, 12'h2AA, 0, "R1 other device");
      issue(12'o7031, 12'h2AA, 0, 12'h2AA, 0, "R1 other opcode");
      issue(12'o6001, 12'h155, 0, 12'h155, 0, "R1 device zero");
      // printer
      issue(12'o6041, 12'o0000, 0, 12'o0000, 0, "R8 prn flag clear");
      prn_q.push_back(8'hC1);
      issue(12'o6044, 12'h0C1, 0, 12'h0C1, 0, "R12 print no write");
      issue(12'o6041, 12'o0000, 0, 12'o0000, 0, "R9 flag clear while busy");
      idle(PRN_LAT + 3);
      issue(12'o6041, 12'o0000, 0, 12'o0000, 1, "R9 flag after done");
      issue(12'o6042, 12'o0000, 0, 12'o0000, 0, "R8 clear prn flag");
      issue(12'o6041, 12'o0000, 0, 12'o0000, 0, "R8 prn flag cleared");
      issue(12'o6044, 12'h700, 0, 12'h700, 0, "R10 zero print");
      issue(12'o6041, 12'o0000, 0, 12'o0000, 1, "R10 flag at once");
      prn_q.push_back(8'h52);
      issue(12'o6046, 12'h052, 0, 12'h052, 0, "R11 clear and print");
      issue(12'o6041, 12'o0000, 0, 12'o0000, 0, "R11 flag cleared");
      idle(PRN_LAT + 3);
      issue(12'o6041, 12'o0000, 0, 12'o0000, 1, "R11 flag after done");
      issue(12'o6046, 12'hF00, 0, 12'hF00, 0, "R10 zero with clear");
      issue(12'o6041, 12'o0000, 0, 12'o0000, 1, "R10 flag set wins");
      idle(PRN_LAT + 3);
      check("R9 all prints started", prn_q.size(), 0);
      check("R1 all expectations consumed", cpu_q.size(), 0);
      finish_run();
   end
endmodule